// File: doc/BRIEF.md
# Microcoded CPU Control Sequencer

This block is the control unit of a small 8-bit accumulator processor. Each clock it combines the current 5-bit opcode, the carry and zero flags and its own 3-bit micro-step into a 10-bit control-store address. It then looks up a 20-bit control word that drives the datapath. The control store is a synthesizable lookup inside the block and covers 19 instructions. The datapath, memory and ALU sit outside the block. Only the control words, the micro-step, the address and a halt indication leave it.

The micro-step is held in an enumerated state register with eight states, `STEP_0` through `STEP_7`. Three transitions are possible:

- **advance**: move to the next state, with `STEP_7` wrapping to `STEP_0`.
- **retire**: return to `STEP_0` when the end bit (bit 4) of the current word is set.
- **freeze**: stay in place while the halt bit (bit 15) of the current word is set.

A synchronous active-high reset forces `STEP_0` and takes precedence over all three transitions.

Because the flags form part of the address, a conditional jump runs a different micro-sequence depending on the flag it tests. No gating logic is involved.

Top module: `cpu_useq_ctrl`

## Requirements
- R1: While `rst` is high at a rising edge, the step goes to 0. After that edge `step_o` reads 0 and `ctrl_o` shows the step-0 word for the presented opcode.
- R2: For every opcode 0x00..0x12 and every flag value, step 0 emits 0x00104 and step 1 emits 0x00068.
- R3: From step 2 the execute words are emitted in order:
  - HALT 0x01: 0x08000
  - LDA imm 0x02: 0x0010C, 0x04040
  - LDA mem 0x03: 0x0010C, 0x00140, 0x04040
  - STA 0x04: 0x0010C, 0x00140, 0x02080
  - LDB imm 0x05: 0x0010C, 0x00440
  - LDB mem 0x06: 0x0010C, 0x00140, 0x00440
  - STB 0x07: 0x0010C, 0x00140, 0x00280
  - ADD imm 0x08: 0x0010C, 0x00440, 0x15000
  - ADD mem 0x09: 0x0010C, 0x00140, 0x00440, 0x15000
  - SUB imm 0x0A: 0x0010C, 0x00C40, 0x15800
  - SUB mem 0x0B: 0x0010C, 0x00140, 0x00C40, 0x15800
  - OUTA 0x0C: 0x02001
  - OUTB 0x0D: 0x00201
  - OUT imm 0x0E: 0x0010C, 0x00041
  - OUT mem 0x0F: 0x0010C, 0x00140, 0x00041
  - JP 0x10: 0x0010C, 0x00042
  - NOP 0x00 has no execute words.
- R4: The word after the last execute word is 0x00010 (bit 4 set), and at the next edge the step returns to 0.
- R5: When neither bit 4 nor bit 15 of the current word is set and reset is low, the step advances by one at each edge, wrapping from 7 to 0.
- R6: JPZ 0x11 runs the JP sequence when `zero_i` is 1 and the single word 0x00008 when `zero_i` is 0, whatever `carry_i` is.
- R7: JPC 0x12 runs the JP sequence when `carry_i` is 1 and the single word 0x00008 when `carry_i` is 0, whatever `zero_i` is.
- R8: Every opcode other than 0x11 and 0x12 gives the same word sequence for all four carry/zero combinations.
- R9: Undefined addresses emit 0x00000. These are every step of opcodes 0x13..0x1F and every step after the end word of a defined opcode.
- R10: While bit 15 of the current word is set, `halt_o` is 1 and the step holds its value at every edge.
- R11: Reset asserted while the block is halted still returns the step to 0 and drops `halt_o`.
- R12: `uaddr_o` equals {opcode[4:0], carry, zero, step[2:0]}, so the opcode is at bits 9..5, carry at bit 4, zero at bit 3 and the step at bits 2..0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| opcode_i | input | 5 | Opcode from the instruction register |
| carry_i | input | 1 | Carry flag from the ALU |
| zero_i | input | 1 | Zero flag from the ALU |
| ctrl_o | output | 20 | Control word for the datapath |
| step_o | output | 3 | Current micro-step |
| uaddr_o | output | 10 | Control-store address |
| halt_o | output | 1 | High while the current word carries the halt bit |

## Verification
Reset can coincide with the freeze transition. The halt word is still present when reset rises, so the two requests meet in the same cycle. The bench runs HALT under every flag combination, lets the step sit frozen for several cycles, and then raises reset while `halt_o` is still high. The check passes only if the step reads 0 and `halt_o` reads 0 after that edge.

The end bit and the increment also meet at every instruction boundary. The sweep across all 32 opcodes and four flag combinations compares each step against an arithmetic step model, so a counter that advances past an end word is caught.

// File: rtl/cpu_useq_pkg.sv
package cpu_useq_pkg;

    localparam int OP_W     = 5;
    localparam int STEP_W   = 3;
    localparam int CW_W     = 20;
    localparam int ADDR_W   = OP_W + 2 + STEP_W;
    localparam int END_BIT  = 4;
    localparam int HALT_BIT = 15;
    localparam int LAST_OP  = 18;
    localparam int MAX_EXEC = 4;

    typedef enum logic [STEP_W-1:0] {
        STEP_0, STEP_1, STEP_2, STEP_3, STEP_4, STEP_5, STEP_6, STEP_7
    } step_e;

    localparam logic [CW_W-1:0] CW_FETCH_A = 20'h00104;
    localparam logic [CW_W-1:0] CW_FETCH_B = 20'h00068;
    localparam logic [CW_W-1:0] CW_RETIRE  = 20'h00010;
    localparam logic [CW_W-1:0] CW_SKIP    = 20'h00008;
    localparam logic [CW_W-1:0] CW_OPND    = 20'h0010C;
    localparam logic [CW_W-1:0] CW_DEREF   = 20'h00140;

    typedef struct packed {
        logic [CW_W-1:0] w0;
        logic [CW_W-1:0] w1;
        logic [CW_W-1:0] w2;
        logic [CW_W-1:0] w3;
        logic [2:0]      len;
    } exec_seq_t;

    // Execute phase of each opcode; flags pick the conditional-jump variant.
    function automatic exec_seq_t exec_seq(input logic [OP_W-1:0] op,
                                           input logic cy, input logic zr);
        exec_seq_t s;
        s = '0;
        case (op)
            5'h00: s.len = 3'd0;
            5'h01: begin s.w0 = 20'h08000; s.len = 3'd1; end
            5'h02: begin s.w0 = CW_OPND; s.w1 = 20'h04040; s.len = 3'd2; end
            5'h03: begin s.w0 = CW_OPND; s.w1 = CW_DEREF; s.w2 = 20'h04040; s.len = 3'd3; end
            5'h04: begin s.w0 = CW_OPND; s.w1 = CW_DEREF; s.w2 = 20'h02080; s.len = 3'd3; end
            5'h05: begin s.w0 = CW_OPND; s.w1 = 20'h00440; s.len = 3'd2; end
            5'h06: begin s.w0 = CW_OPND; s.w1 = CW_DEREF; s.w2 = 20'h00440; s.len = 3'd3; end
            5'h07: begin s.w0 = CW_OPND; s.w1 = CW_DEREF; s.w2 = 20'h00280; s.len = 3'd3; end
            5'h08: begin s.w0 = CW_OPND; s.w1 = 20'h00440; s.w2 = 20'h15000; s.len = 3'd3; end
            5'h09: begin s.w0 = CW_OPND; s.w1 = CW_DEREF; s.w2 = 20'h00440;
                         s.w3 = 20'h15000; s.len = 3'd4; end
            5'h0A: begin s.w0 = CW_OPND; s.w1 = 20'h00C40; s.w2 = 20'h15800; s.len = 3'd3; end
            5'h0B: begin s.w0 = CW_OPND; s.w1 = CW_DEREF; s.w2 = 20'h00C40;
                         s.w3 = 20'h15800; s.len = 3'd4; end
            5'h0C: begin s.w0 = 20'h02001; s.len = 3'd1; end
            5'h0D: begin s.w0 = 20'h00201; s.len = 3'd1; end
            5'h0E: begin s.w0 = CW_OPND; s.w1 = 20'h00041; s.len = 3'd2; end
            5'h0F: begin s.w0 = CW_OPND; s.w1 = CW_DEREF; s.w2 = 20'h00041; s.len = 3'd3; end
            5'h10: begin s.w0 = CW_OPND; s.w1 = 20'h00042; s.len = 3'd2; end
            5'h11: begin
                if (zr) begin s.w0 = CW_OPND; s.w1 = 20'h00042; s.len = 3'd2; end
                else    begin s.w0 = CW_SKIP; s.len = 3'd1; end
            end
            5'h12: begin
                if (cy) begin s.w0 = CW_OPND; s.w1 = 20'h00042; s.len = 3'd2; end
                else    begin s.w0 = CW_SKIP; s.len = 3'd1; end
            end
            default: s = '0;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/useq_addr_build.sv
module useq_addr_build
    import cpu_useq_pkg::*;
(
    input  logic [OP_W-1:0]   opcode,
    input  logic              carry,
    input  logic              zero,
    input  step_e             step,
    output logic [ADDR_W-1:0] uaddr
);
    // Opcode high, flags in the middle, step low: 8 steps per flag pair.
    always_comb begin
        uaddr = {opcode, carry, zero, step};
    end
endmodule

// File: rtl/useq_ctrl_store.sv
module useq_ctrl_store
    import cpu_useq_pkg::*;
(
    input  logic [ADDR_W-1:0] uaddr,
    output logic [CW_W-1:0]   word
);
    localparam int OP_LSB = 2 + STEP_W;

    logic [OP_W-1:0]   a_op;
    logic              a_cy;
    logic              a_zr;
    logic [STEP_W-1:0] a_st;
    exec_seq_t         seq;
    logic [STEP_W-1:0] exec_idx;

    always_comb begin
        a_op     = uaddr[ADDR_W-1:OP_LSB];
        a_cy     = uaddr[STEP_W+1];
        a_zr     = uaddr[STEP_W];
        a_st     = uaddr[STEP_W-1:0];
        seq      = exec_seq(a_op, a_cy, a_zr);
        exec_idx = a_st - 3'd2;
        word     = '0;
        if (int'(a_op) <= LAST_OP) begin
            unique case (a_st)
                3'd0: word = CW_FETCH_A;
                3'd1: word = CW_FETCH_B;
                default: begin
                    if (exec_idx < seq.len) begin
                        unique case (exec_idx[1:0])
                            2'd0: word = seq.w0;
                            2'd1: word = seq.w1;
                            2'd2: word = seq.w2;
                            2'd3: word = seq.w3;
                        endcase
                    end else if (exec_idx == seq.len) begin
                        word = CW_RETIRE;
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/useq_step_fsm.sv
module useq_step_fsm
    import cpu_useq_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  end_req,
    input  logic  halt_req,
    output step_e step
);
    step_e step_q;
    step_e step_adv;
    step_e step_d;

    // Successor state for the advance transition.
    always_comb begin
        unique case (step_q)
            STEP_0: step_adv = STEP_1;
            STEP_1: step_adv = STEP_2;
            STEP_2: step_adv = STEP_3;
            STEP_3: step_adv = STEP_4;
            STEP_4: step_adv = STEP_5;
            STEP_5: step_adv = STEP_6;
            STEP_6: step_adv = STEP_7;
            STEP_7: step_adv = STEP_0;
        endcase
        if (halt_req)     step_d = step_q;    // freeze
        else if (end_req) step_d = STEP_0;    // retire
        else              step_d = step_adv;  // advance
    end

    always_ff @(posedge clk) begin
        if (rst) step_q <= STEP_0;
        else     step_q <= step_d;
    end

    always_comb step = step_q;

    p_reset_r1: assert property (@(posedge clk) rst |=> step_q == STEP_0);
    p_end_clear_r4: assert property (@(posedge clk) disable iff (rst)
        (end_req && !halt_req) |=> step_q == STEP_0);
    p_halt_hold_r10: assert property (@(posedge clk) disable iff (rst)
        halt_req |=> $stable(step_q));
    p_step_inc_r5: assert property (@(posedge clk) disable iff (rst)
        (!end_req && !halt_req) |=> (3'(step_q) == 3'($past(step_q) + 3'd1)));
endmodule

// File: rtl/cpu_useq_ctrl.sv
module cpu_useq_ctrl
    import cpu_useq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [OP_W-1:0]   opcode_i,
    input  logic              carry_i,
    input  logic              zero_i,
    output logic [CW_W-1:0]   ctrl_o,
    output logic [STEP_W-1:0] step_o,
    output logic [ADDR_W-1:0] uaddr_o,
    output logic              halt_o
);
    step_e             step;
    logic [ADDR_W-1:0] uaddr;
    logic [CW_W-1:0]   word;

    useq_addr_build u_addr (
        .opcode (opcode_i),
        .carry  (carry_i),
        .zero   (zero_i),
        .step   (step),
        .uaddr  (uaddr)
    );

    useq_ctrl_store u_store (
        .uaddr (uaddr),
        .word  (word)
    );

    useq_step_fsm u_fsm (
        .clk      (clk),
        .rst      (rst),
        .end_req  (word[END_BIT]),
        .halt_req (word[HALT_BIT]),
        .step     (step)
    );

    always_comb begin
        ctrl_o  = word;
        step_o  = step;
        uaddr_o = uaddr;
        halt_o  = word[HALT_BIT];
    end

    p_fetch_word_r2: assert property (@(posedge clk) disable iff (rst)
        (step == STEP_0 && int'(opcode_i) <= LAST_OP) |-> ctrl_o == CW_FETCH_A);
    p_cond_skip_r6: assert property (@(posedge clk) disable iff (rst)
        (opcode_i == 5'h11 && !zero_i && step == STEP_2) |-> ctrl_o == CW_SKIP);
    p_cond_skip_r7: assert property (@(posedge clk) disable iff (rst)
        (opcode_i == 5'h12 && !carry_i && step == STEP_2) |-> ctrl_o == CW_SKIP);
    p_undef_zero_r9: assert property (@(posedge clk) disable iff (rst)
        (int'(opcode_i) > LAST_OP) |-> ctrl_o == '0);
endmodule

// File: tb/sim_cpu_useq_ctrl.sv
module sim_cpu_useq_ctrl;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [4:0]  opcode_i = '0;
    logic        carry_i = 1'b0;
    logic        zero_i = 1'b0;
    logic [19:0] ctrl_o;
    logic [2:0]  step_o;
    logic [9:0]  uaddr_o;
    logic        halt_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;  // 250 MHz

    cpu_useq_ctrl u0 (
        .clk(clk), .rst(rst), .opcode_i(opcode_i), .carry_i(carry_i),
        .zero_i(zero_i), .ctrl_o(ctrl_o), .step_o(step_o),
        .uaddr_o(uaddr_o), .halt_o(halt_o)
    );

    // Expected execute word k of an opcode (R3, R6, R7); returns count in n.
    function automatic logic [19:0] exp_exec(input int op, input bit c, input bit z,
                                             input int k, output int n);
        logic [19:0] w [4];
        w = '{default: 20'h0};
        n = 0;
        if (op == 1)  begin w[0] = 20'h08000; n = 1; end
        if (op == 2)  begin w[0] = 20'h0010C; w[1] = 20'h04040; n = 2; end
        if (op == 3)  begin w[0] = 20'h0010C; w[1] = 20'h00140; w[2] = 20'h04040; n = 3; end
        if (op == 4)  begin w[0] = 20'h0010C; w[1] = 20'h00140; w[2] = 20'h02080; n = 3; end
        if (op == 5)  begin w[0] = 20'h0010C; w[1] = 20'h00440; n = 2; end
        if (op == 6)  begin w[0] = 20'h0010C; w[1] = 20'h00140; w[2] = 20'h00440; n = 3; end
        if (op == 7)  begin w[0] = 20'h0010C; w[1] = 20'h00140; w[2] = 20'h00280; n = 3; end
        if (op == 8)  begin w[0] = 20'h0010C; w[1] = 20'h00440; w[2] = 20'h15000; n = 3; end
        if (op == 9)  begin w[0] = 20'h0010C; w[1] = 20'h00140; w[2] = 20'h00440; w[3] = 20'h15000; n = 4; end
        if (op == 10) begin w[0] = 20'h0010C; w[1] = 20'h00C40; w[2] = 20'h15800; n = 3; end
        if (op == 11) begin w[0] = 20'h0010C; w[1] = 20'h00140; w[2] = 20'h00C40; w[3] = 20'h15800; n = 4; end
        if (op == 12) begin w[0] = 20'h02001; n = 1; end
        if (op == 13) begin w[0] = 20'h00201; n = 1; end
        if (op == 14) begin w[0] = 20'h0010C; w[1] = 20'h00041; n = 2; end
        if (op == 15) begin w[0] = 20'h0010C; w[1] = 20'h00140; w[2] = 20'h00041; n = 3; end
        if (op == 16 || (op == 17 && z) || (op == 18 && c)) begin
            w[0] = 20'h0010C; w[1] = 20'h00042; n = 2;
        end else if (op == 17 || op == 18) begin
            w[0] = 20'h00008; n = 1;
        end
        return (k >= 0 && k < 4) ? w[k] : 20'h0;
    endfunction

    function automatic logic [19:0] exp_word(input int op, input bit c, input bit z, input int st);
        int n;
        logic [19:0] e;
        if (op > 18) return 20'h0;
        if (st == 0) return 20'h00104;
        if (st == 1) return 20'h00068;
        e = exp_exec(op, c, z, st - 2, n);
        if (st - 2 < n)  return e;
        if (st - 2 == n) return 20'h00010;
        return 20'h0;
    endfunction

    function automatic string word_req(input int op, input bit c, input bit z, input int st);
        if (op > 18) return "R9";
        if (st < 2) return "R2";
        if (op == 17) return "R6";
        if (op == 18) return "R7";
        if (c || z) return "R8";
        return "R3/R4/R9";
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp, input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    // One run of an opcode under one flag pair; model step arithmetically.
    task automatic run_case(input int op, input bit c, input bit z);
        int st;
        logic [19:0] w;
        @(negedge clk);
        rst = 1'b1;
        opcode_i = 5'(op); carry_i = c; zero_i = z;
        @(posedge clk);
        @(negedge clk);
        check((op == 1) ? "R11" : "R1", 32'(step_o), 32'd0, "step after reset");
        check("R1", 32'(ctrl_o), 32'(exp_word(op, c, z, 0)), "word after reset");
        if (op == 1) check("R11", 32'(halt_o), 32'd0, "halt dropped by reset");
        rst = 1'b0;
        st = 0;
        for (int cyc = 0; cyc < 10; cyc++) begin
            w = exp_word(op, c, z, st);
            @(posedge clk);
            @(negedge clk);
            if (w[15])      st = st;
            else if (w[4])  st = 0;
            else            st = (st + 1) % 8;
            check(w[15] ? "R10" : (w[4] ? "R4" : "R5"), 32'(step_o), 32'(st), "step");
            check(word_req(op, c, z, st), 32'(ctrl_o), 32'(exp_word(op, c, z, st)), "ctrl word");
            check("R12", 32'(uaddr_o), {22'd0, 5'(op), c, z, 3'(st)}, "address");
            check("R10", 32'(halt_o), 32'(exp_word(op, c, z, st) >> 15) & 32'd1, "halt");
        end
    endtask

    initial begin
        for (int op = 0; op < 32; op++)
            for (int f = 0; f < 4; f++)
                run_case(op, f[1], f[0]);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < 100000; i++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule